// File: doc/BRIEF.md
# Unaligned Load Combiner

This block takes byte, halfword and word load requests at any byte address and serves them from a memory that returns one 8-byte line per read. It works out whether the requested bytes fit inside one aligned line. If they do, it issues a single line read. If they cross into the next line, it issues two reads, one after the other, and keeps the first line until the second arrives. It then selects the requested bytes from the gathered data and packs them into a zero-extended 32-bit result.

The byte order of the result is chosen per request by a mode input, so software can switch between little-endian and big-endian between accesses. Address, size and mode are all captured when a request is accepted. The request side uses a valid/ready handshake. The memory side sees a one-cycle read strobe with a line address. It answers with a one-cycle data-valid pulse that carries the 64-bit line.

Top module: `ualign_load`

## Requirements
- R1: `req_ready` is high only while the block is idle. After a request is accepted, it stays low until the cycle after `done`.
- R2: In the cycle after acceptance, the block raises `mem_rd_en` for exactly one cycle, with `mem_rd_line` equal to the request address shifted right by three.
- R3: An access whose start offset within its line plus its byte count is at most 8 uses exactly one read. `done` rises in the cycle after the clock edge that samples the last `mem_rd_valid` pulse.
- R4: An access whose start offset within its line plus its byte count exceeds 8 uses exactly two reads. The second read is issued in the cycle after the first data arrives, with line address first line + 1.
- R5: The n requested bytes are the bytes at offsets off..off+n-1 of the 16-byte window made of the first line (bytes 0–7) followed by the second line (bytes 8–15).
- R6: With `req_big_endian` = 0, the byte at the lowest address lands in result bits [7:0], and each later byte lands one byte position higher.
- R7: With `req_big_endian` = 1, the byte at the lowest address lands in the most significant byte of the n-byte value (bits [8n-1:8n-8]), and each later byte lands one byte position lower.
- R8: `req_size` selects the byte count: 00 is 1 byte, 01 is 2 bytes, and 10 or 11 is 4 bytes. Result bits above 8n are zero.
- R9: Changes to `req_addr`, `req_size` or `req_big_endian` after acceptance do not affect the access in progress.
- R10: `done` is a one-cycle pulse, and `result` is zero whenever `done` is low.
- R11: During and after reset, `req_ready` = 1, `mem_rd_en` = 0, `done` = 0 and `result` = 0. A reset in the middle of an access abandons it without a `done`.
- R12: The second line address wraps modulo the line address space, so an access at the top of memory takes its upper bytes from line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Byte count code (00=1, 01=2, 1x=4) |
| req_big_endian | input | 1 | 1 selects big-endian packing |
| mem_rd_en | output | 1 | One-cycle line read strobe |
| mem_rd_line | output | ADDR_W-3 | Line address of the read |
| mem_rd_valid | input | 1 | One-cycle pulse marking returned line data |
| mem_rd_data | input | 64 | Returned line, byte 0 in bits [7:0] |
| done | output | 1 | Result valid this cycle |
| result | output | 32 | Packed, zero-extended load data |

## Verification
The bench concentrates on the boundaries of the split decision. It uses accesses that end exactly on the last byte of a line, and accesses that overrun it by one byte. A wrong comparison there either loses the upper bytes or issues a needless second read. It runs both byte orders on split words, including a word that starts at offset 6. Mixing up the order of the window halves or the packing direction shows up as permuted bytes. It also uses a load that wraps past the top of the address space, where a line counter that saturates or is too narrow would fetch the wrong second line. It changes mode, address and size while an access is in flight, to expose logic that reads the live inputs instead of the captured ones. It also resets in the middle of an access, which catches a state machine that resumes stale work.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

  localparam int LINE_BYTES = 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WIN_W      = 2 * LINE_W;
  localparam int RES_BYTES  = 4;
  localparam int RES_W      = RES_BYTES * 8;
  localparam int CNT_W      = $clog2(RES_BYTES) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_LO,
    ST_WAIT_LO,
    ST_ISSUE_HI,
    ST_WAIT_HI,
    ST_DONE
  } ual_state_t;

  typedef struct packed {
    logic [OFF_W-1:0] off;
    logic [CNT_W-1:0] nbytes;
    logic             big_end;
  } ual_shape_t;

  // Byte count for a size code; both upper codes mean a full word.
  function automatic logic [CNT_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(2);
      default: return CNT_W'(RES_BYTES);
    endcase
  endfunction

  // True when the access runs past the last byte of its line.
  function automatic logic spans_lines(input logic [OFF_W-1:0] off,
                                       input logic [CNT_W-1:0] nb);
    return (int'(off) + int'(nb)) > LINE_BYTES;
  endfunction

  // Select nb bytes from the window starting at off and pack them.
  function automatic logic [RES_W-1:0] pack_bytes(input logic [WIN_W-1:0] win,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [CNT_W-1:0] nb,
                                                  input logic             big_end);
    logic [RES_W-1:0] r;
    logic [7:0]       b;
    r = '0;
    for (int k = 0; k < RES_BYTES; k++) begin
      if (k < int'(nb)) begin
        b = win[(int'(off) + k) * 8 +: 8];
        if (big_end) r[(int'(nb) - 1 - k) * 8 +: 8] = b;
        else         r[k * 8 +: 8] = b;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ualign_ctrl.sv
module ualign_ctrl
  import ualign_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic split,
  input  logic mem_rd_valid,
  output logic idle,
  output logic rd_issue,
  output logic rd_second,
  output logic lo_load,
  output logic hi_load,
  output logic finish
);

  ual_state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept) state_d = ST_ISSUE_LO;
      ST_ISSUE_LO: state_d = ST_WAIT_LO;
      ST_WAIT_LO:  if (mem_rd_valid) state_d = split ? ST_ISSUE_HI : ST_DONE;
      ST_ISSUE_HI: state_d = ST_WAIT_HI;
      ST_WAIT_HI:  if (mem_rd_valid) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign idle      = (state_q == ST_IDLE);
  assign rd_second = (state_q == ST_ISSUE_HI);
  assign rd_issue  = (state_q == ST_ISSUE_LO) || rd_second;
  assign lo_load   = (state_q == ST_WAIT_LO) && mem_rd_valid;
  assign hi_load   = (state_q == ST_WAIT_HI) && mem_rd_valid;
  assign finish    = (state_q == ST_DONE);

endmodule

// File: rtl/ualign_linebuf.sv
module ualign_linebuf
  import ualign_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        load,
  input  logic [LINE_W-1:0]       data,
  output logic [SLOTS*LINE_W-1:0] window
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [LINE_W-1:0] line_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       line_q <= '0;
      else if (load[g]) line_q <= data;
    end
    assign window[g*LINE_W +: LINE_W] = line_q;
  end

endmodule

// File: rtl/ualign_extract.sv
module ualign_extract
  import ualign_pkg::*;
(
  input  logic [WIN_W-1:0] window,
  input  ual_shape_t       shape,
  input  logic             enable,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] packed_w;

  assign packed_w = pack_bytes(window, shape.off, shape.nbytes, shape.big_end);
  assign result   = enable ? packed_w : '0;

endmodule

// File: rtl/ualign_load.sv
module ualign_load
  import ualign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_big_endian,
  output logic                    mem_rd_en,
  output logic [ADDR_W-OFF_W-1:0] mem_rd_line,
  input  logic                    mem_rd_valid,
  input  logic [LINE_W-1:0]       mem_rd_data,
  output logic                    done,
  output logic [RES_W-1:0]        result
);

  localparam int LA_W = ADDR_W - OFF_W;

  logic             accept;
  logic             idle;
  logic             rd_issue;
  logic             rd_second;
  logic             lo_load;
  logic             hi_load;
  logic             finish;
  logic             acc_split;
  logic [LA_W-1:0]  base_line_q;
  ual_shape_t       shape_q;
  logic [WIN_W-1:0] window;

  assign accept = req_valid && idle;

  // Request fields are frozen here for the whole access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_line_q <= '0;
      shape_q     <= '0;
    end else if (accept) begin
      base_line_q     <= req_addr[ADDR_W-1:OFF_W];
      shape_q.off     <= req_addr[OFF_W-1:0];
      shape_q.nbytes  <= size_bytes(req_size);
      shape_q.big_end <= req_big_endian;
    end
  end

  assign acc_split = spans_lines(shape_q.off, shape_q.nbytes);

  ualign_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .split        (acc_split),
    .mem_rd_valid (mem_rd_valid),
    .idle         (idle),
    .rd_issue     (rd_issue),
    .rd_second    (rd_second),
    .lo_load      (lo_load),
    .hi_load      (hi_load),
    .finish       (finish)
  );

  ualign_linebuf #(.SLOTS(2)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   ({hi_load, lo_load}),
    .data   (mem_rd_data),
    .window (window)
  );

  ualign_extract u_ext (
    .window (window),
    .shape  (shape_q),
    .enable (finish),
    .result (result)
  );

  assign req_ready   = idle;
  assign mem_rd_en   = rd_issue;
  assign mem_rd_line = !rd_issue ? '0 :
                       rd_second ? LA_W'(base_line_q + 1'b1) : base_line_q;
  assign done        = finish;

endmodule

// File: rtl/ualign_load_chk.sv
module ualign_load_chk
  import ualign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    mem_rd_en,
  input logic [ADDR_W-OFF_W-1:0] mem_rd_line,
  input logic                    mem_rd_valid,
  input logic                    done,
  input logic [RES_W-1:0]        result,
  input logic                    acc_split,
  input logic                    rd_second
);

  localparam int LA_W = ADDR_W - OFF_W;

  logic [1:0]      rd_seen;
  logic [LA_W-1:0] first_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen    <= '0;
      first_line <= '0;
    end else begin
      if (req_valid && req_ready)          rd_seen <= '0;
      else if (mem_rd_en && rd_seen != 2'd3) rd_seen <= rd_seen + 2'd1;
      if (mem_rd_en && !rd_second)         first_line <= mem_rd_line;
    end
  end

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  no_read_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_en && mem_rd_line == $past(req_addr[ADDR_W-1:OFF_W])));

  // R3
  done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd_valid));

  // R3
  read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_seen == (acc_split ? 2'd2 : 2'd1)));

  // R4
  next_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_second |-> (mem_rd_line == LA_W'(first_line + 1'b1)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (result == '0));

endmodule

bind ualign_load ualign_load_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_line  (mem_rd_line),
  .mem_rd_valid (mem_rd_valid),
  .done         (done),
  .result       (result),
  .acc_split    (acc_split),
  .rd_second    (rd_second)
);

// File: tb/ualign_load_tb.sv
`timescale 1ns/1ps
module ualign_load_tb;

  localparam int AW   = 32;
  localparam int LAW  = AW - 3;
  localparam int NVEC = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [AW-1:0]  req_addr = '0;
  logic [1:0]     req_size = '0;
  logic           req_big_endian = 1'b0;
  logic           mem_rd_en;
  logic [LAW-1:0] mem_rd_line;
  logic           mem_rd_valid = 1'b0;
  logic [63:0]    mem_rd_data = '0;
  logic           done;
  logic [31:0]    result;

  int n_checks = 0;
  int n_fail   = 0;
  int lat_cfg  = 1;
  int rd_count = 0;
  logic [LAW-1:0] seen_line [4];

  always #2 clk = ~clk;

  ualign_load #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_big_endian(req_big_endian),
    .mem_rd_en(mem_rd_en), .mem_rd_line(mem_rd_line), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .done(done), .result(result)
  );

  // Memory contents: distinct bytes at neighbouring addresses.
  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return 8'(a * 37 + (a >> 8) + 90);
  endfunction

  function automatic logic [63:0] line_data(input logic [LAW-1:0] l);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[i*8 +: 8] = mem_byte({l, 3'(i)});
    return d;
  endfunction

  function automatic logic [31:0] exp_res(input logic [AW-1:0] a, input logic [1:0] sz,
                                          input logic be);
    int n;
    logic [31:0] r;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    r = '0;
    for (int k = 0; k < n; k++) begin
      if (be) r[(n-1-k)*8 +: 8] = mem_byte(AW'(a + k));
      else    r[k*8 +: 8]       = mem_byte(AW'(a + k));
    end
    return r;
  endfunction

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Memory responder: one data pulse lat_cfg cycles after each strobe.
  initial begin
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (mem_rd_en && rst_n) begin
        logic [LAW-1:0] l;
        l = mem_rd_line;
        if (rd_count < 4) seen_line[rd_count] = l;
        rd_count++;
        repeat (lat_cfg) @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data  = line_data(l);
      end
    end
  end

  task automatic run_load(input logic [AW-1:0] a, input logic [1:0] sz, input logic be,
                          input int lat, input int nrd, input logic flip);
    logic got;
    logic ready_seen;
    @(negedge clk);
    lat_cfg = lat; rd_count = 0;
    req_addr = a; req_size = sz; req_big_endian = be; req_valid = 1'b1;
    @(posedge clk); #1;
    check("R1 ready low after accept", req_ready, 0);
    check("R2 read strobe after accept", mem_rd_en, 1);
    check("R2 first line address", mem_rd_line, a >> 3);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin   // R9: disturb the request inputs mid-access
      req_big_endian = ~be; req_addr = a ^ 32'h55; req_size = 2'b00;
    end
    got = 1'b0; ready_seen = 1'b0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(posedge clk); #1;
      if (req_ready) ready_seen = 1'b1;
      if (done) got = 1'b1;
    end
    check("R1 ready held low while busy", ready_seen, 0);
    check("R3 done reached", got, 1);
    check("R3 done in cycle after data", mem_rd_valid, 1);
    check(nrd == 2 ? "R4 two reads for split" : "R3 one read for contained", rd_count, nrd);
    if (nrd == 2)
      check("R4 R12 second line address", seen_line[1], LAW'((a >> 3) + 1));
    check(be ? "R7 R5 R8 big-endian result" : "R6 R5 R8 little-endian result",
          result, exp_res(a, sz, be));
    @(posedge clk); #1;
    check("R10 done is one cycle", done, 0);
    check("R10 result zero when idle", result, 0);
    check("R1 ready back after done", req_ready, 1);
  endtask

  // {addr, size, big_endian, latency, reads}
  localparam logic [38:0] VECS [NVEC] = '{
    {32'h0000_0100, 2'b00, 1'b0, 2'd1, 2'd1},
    {32'h0000_0107, 2'b00, 1'b1, 2'd1, 2'd1},
    {32'h0000_0106, 2'b01, 1'b0, 2'd1, 2'd1},
    {32'h0000_0107, 2'b01, 1'b0, 2'd2, 2'd2},
    {32'h0000_0107, 2'b01, 1'b1, 2'd1, 2'd2},
    {32'h0000_0104, 2'b10, 1'b0, 2'd1, 2'd1},
    {32'h0000_0106, 2'b10, 1'b0, 2'd2, 2'd2},
    {32'h0000_0106, 2'b10, 1'b1, 2'd3, 2'd2},
    {32'h0000_0105, 2'b10, 1'b1, 2'd1, 2'd2},
    {32'h0000_0200, 2'b10, 1'b1, 2'd1, 2'd1},
    {32'h0000_0203, 2'b10, 1'b0, 2'd1, 2'd1},
    {32'h0000_01FC, 2'b10, 1'b0, 2'd1, 2'd1},
    {32'h0000_01FD, 2'b10, 1'b0, 2'd1, 2'd2},
    {32'h0000_0300, 2'b11, 1'b0, 2'd1, 2'd1},
    {32'h0000_0003, 2'b01, 1'b1, 2'd3, 2'd1},
    {32'h0000_0000, 2'b10, 1'b0, 2'd1, 2'd1}
  };

  initial begin
    #800000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R11: state while reset is held, with a request pending
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 ready in reset", req_ready, 1);
    check("R11 no read in reset", mem_rd_en, 0);
    check("R11 done low in reset", done, 0);
    check("R11 result zero in reset", result, 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 idle after reset", {req_ready, mem_rd_en, done}, 3'b100);

    for (int v = 0; v < NVEC; v++) begin
      logic [38:0] e;
      e = VECS[v];
      run_load(e[38:7], e[6:5], e[4], int'(e[3:2]), int'(e[1:0]), 1'b0);
    end

    // R12: wrap from the top line to line 0
    run_load(32'hFFFF_FFFE, 2'b10, 1'b0, 1, 2, 1'b0);
    run_load(32'hFFFF_FFFD, 2'b10, 1'b1, 2, 2, 1'b0);

    // R9: inputs changed during contained and split accesses
    run_load(32'h0000_0106, 2'b10, 1'b0, 2, 2, 1'b1);
    run_load(32'h0000_0400, 2'b01, 1'b1, 3, 1, 1'b1);

    // R11: reset in the middle of a split access
    @(negedge clk);
    lat_cfg = 3; rd_count = 0;
    req_addr = 32'h0000_0507; req_size = 2'b10; req_big_endian = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 mid-access reset ready", req_ready, 1);
    check("R11 mid-access reset no strobe", mem_rd_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      logic done_seen;
      done_seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(posedge clk); #1;
        if (done || mem_rd_en) done_seen = 1'b1;
      end
      check("R11 abandoned access stays silent", done_seen, 0);
    end
    run_load(32'h0000_0602, 2'b01, 1'b0, 1, 1, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule